// File: doc/BRIEF.md
# Variable-Length Instruction Stream Parser

The parser takes instruction bytes one at a time over a valid/ready handshake and rebuilds whole instructions from them. The top two bits of each leading opcode byte fix how many bytes the instruction occupies: two, four or six. The parser collects that many bytes, classifies the instruction into one of six layouts, splits it into named fields and presents one decoded record on an output valid/ready handshake.

The record carries a format code, a 16-bit opcode field, two register fields, two base/displacement pairs, an immediate or length byte, the byte count and a flag for an illegal opcode. Fields that the format does not define are zero. One four-byte layout uses a two-byte opcode, so every field after it moves by one byte. The opcodes that take this layout come from a parameter list. A parameter bit map selects which opcodes in the 0x80-0x9F range take the immediate layout.

The parser holds a finished record until it is taken. It only stalls the input while that record waits and the final byte of the next instruction is offered. Bytes are never dropped or repeated, so the stream stays aligned to instruction boundaries.

Top module: `vlip_parser`

## Requirements
- R1: The first byte sets the length from its bits [7:6]: 00 gives 2 bytes, 01 and 10 give 4 bytes, 11 gives 6 bytes. out_nbytes reports this count (2, 4 or 6).
- R2: A 2-byte instruction has format code 0. out_ra is byte1[7:4] and out_rb is byte1[3:0].
- R3: A 4-byte instruction that is neither the two-byte-opcode layout nor the immediate layout has format code 1 when bits [7:6] are 01 and code 2 when they are 10. It gives out_ra = byte1[7:4], out_rb = byte1[3:0], out_base2 = byte2[7:4] and out_disp2 = {byte2[3:0], byte3}.
- R4: An opcode in 0x80-0x9F whose bit (opcode - 0x80) is set in SI_MAP has format code 3. out_imm is byte1, out_base1 is byte2[7:4] and out_disp1 is {byte2[3:0], byte3}.
- R5: A 6-byte instruction has format code 4. out_imm is byte1 (the length byte). Bytes 2-3 give out_base1/out_disp1 and bytes 4-5 give out_base2/out_disp2, with the same nibble split as R3.
- R6: A first byte that matches an entry of SPFX_LIST has format code 5 and out_opcode = {byte0, byte1}, with bytes 2-3 giving out_base2/out_disp2. Every other format gives out_opcode = {8'h00, byte0}. Fields a format does not define read zero.
- R7: out_illegal is 1 exactly when the first byte is 0x00. Such an instruction is still parsed as a 2-byte instruction.
- R8: While out_valid is 1 and out_ready is 0, the record and out_valid hold unchanged.
- R9: in_ready is 0 only while the final byte of an instruction is due and the held record is not being taken in the same cycle. A record becomes valid in the cycle after its final byte is accepted.
- R10: A synchronous active-high reset drops any partly collected instruction and clears out_valid. The next accepted byte is treated as an opcode.
- R11: Instructions sent back to back with no idle cycles come out in order, one record each, with no byte lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Parser can take the byte |
| in_byte | input | 8 | Instruction byte, first byte first |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_fmt | output | 3 | Format code 0..5 |
| out_nbytes | output | 3 | Instruction length in bytes |
| out_opcode | output | 16 | Opcode; upper byte nonzero only for format 5 |
| out_ra | output | 4 | First register field |
| out_rb | output | 4 | Second register / index field |
| out_base1 | output | 4 | First base field |
| out_disp1 | output | 12 | First displacement |
| out_base2 | output | 4 | Second base field |
| out_disp2 | output | 12 | Second displacement |
| out_imm | output | 8 | Immediate or length byte |
| out_illegal | output | 1 | First byte was 0x00 |

## Verification
The assertions assume that out_ready follows the handshake rule and is read only when out_valid is high. They assume nothing about in_byte, because any byte value is a legal opcode for length purposes. The stall property assumes that in_valid, once raised, stays up until the byte is accepted. The bench's byte task keeps this rule by holding the byte until in_ready has been seen high before a clock edge. It also drives every input 2 ns after the rising edge, so the properties never sample an input in the middle of a change.

// File: rtl/vlip_pkg.sv
package vlip_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 6;
  localparam int CNT_W     = $clog2(MAX_BYTES);
  localparam int WORD_W    = BYTE_W * MAX_BYTES;

  typedef enum logic [2:0] {
    FMT_RR = 3'd0, FMT_RX = 3'd1, FMT_RS = 3'd2,
    FMT_SI = 3'd3, FMT_SS = 3'd4, FMT_S  = 3'd5
  } fmt_e;

  typedef struct packed {
    logic [2:0]  nbytes;
    fmt_e        fmt;
    logic [15:0] opcode;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [3:0]  base1;
    logic [11:0] disp1;
    logic [3:0]  base2;
    logic [11:0] disp2;
    logic [7:0]  imm;
    logic        illegal;
  } rec_t;

  // Length class from the two top bits of the leading byte.
  function automatic logic [2:0] insn_bytes(input logic [7:0] op);
    case (op[7:6])
      2'b00:   insn_bytes = 3'd2;
      2'b11:   insn_bytes = 3'd6;
      default: insn_bytes = 3'd4;
    endcase
  endfunction

  function automatic fmt_e pick_format(input logic [7:0] op,
                                       input logic is_s, input logic is_si);
    if (op[7:6] == 2'b00)      pick_format = FMT_RR;
    else if (op[7:6] == 2'b11) pick_format = FMT_SS;
    else if (is_s)             pick_format = FMT_S;
    else if (is_si)            pick_format = FMT_SI;
    else if (op[7:6] == 2'b01) pick_format = FMT_RX;
    else                       pick_format = FMT_RS;
  endfunction

  // Field split; word holds byte0 in its top byte.
  function automatic rec_t split_fields(input logic [WORD_W-1:0] w, input fmt_e f);
    logic [7:0] b0, b1, b2, b3, b4, b5;
    rec_t r;
    {b0, b1, b2, b3, b4, b5} = w;
    r         = '0;
    r.fmt     = f;
    r.nbytes  = insn_bytes(b0);
    r.opcode  = {8'h00, b0};
    r.illegal = (b0 == 8'h00);
    case (f)
      FMT_RR: begin r.ra = b1[7:4]; r.rb = b1[3:0]; end
      FMT_RX, FMT_RS: begin
        r.ra = b1[7:4]; r.rb = b1[3:0];
        r.base2 = b2[7:4]; r.disp2 = {b2[3:0], b3};
      end
      FMT_SI: begin
        r.imm = b1; r.base1 = b2[7:4]; r.disp1 = {b2[3:0], b3};
      end
      FMT_SS: begin
        r.imm = b1; r.base1 = b2[7:4]; r.disp1 = {b2[3:0], b3};
        r.base2 = b4[7:4]; r.disp2 = {b4[3:0], b5};
      end
      default: begin
        r.opcode = {b0, b1}; r.base2 = b2[7:4]; r.disp2 = {b2[3:0], b3};
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vlip_collect.sv
module vlip_collect
  import vlip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              sink_free,
  output logic              in_ready,
  output logic              byte_take,
  output logic              insn_done,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic [WORD_W-1:0] word
);
  logic [CNT_W-1:0] cnt;
  logic [7:0]       held [MAX_BYTES];
  logic [7:0]       lead;
  logic [2:0]       need;
  logic             at_last;

  assign lead    = (cnt == '0) ? in_byte : held[0];
  assign need    = insn_bytes(lead);
  assign at_last = (cnt != '0) && ({1'b0, cnt} + 4'd1 == {1'b0, need});

  assign in_ready  = !at_last || sink_free;
  assign byte_take = in_valid && in_ready;
  assign insn_done = byte_take && at_last;
  assign fill_cnt  = cnt;

  always_comb begin
    for (int k = 0; k < MAX_BYTES; k++)
      word[WORD_W-1-BYTE_W*k -: BYTE_W] = (cnt == CNT_W'(k)) ? in_byte : held[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (byte_take) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAX_BYTES; k++)
      if (byte_take && cnt == CNT_W'(k)) held[k] <= in_byte;
  end
endmodule

// File: rtl/vlip_decode.sv
module vlip_decode
  import vlip_pkg::*;
#(
  parameter int                  NUM_SPFX  = 2,
  parameter logic [NUM_SPFX*8-1:0] SPFX_LIST = {8'hB3, 8'hB2},
  parameter logic [31:0]         SI_MAP    = 32'h00FF_0000
) (
  input  logic [WORD_W-1:0] word,
  output rec_t              rec
);
  logic [7:0]          op;
  logic [NUM_SPFX-1:0] spfx_hit;
  logic                is_s, is_si;

  assign op = word[WORD_W-1 -: 8];

  for (genvar g = 0; g < NUM_SPFX; g++) begin : g_spfx
    assign spfx_hit[g] = (op == SPFX_LIST[g*8 +: 8]);
  end

  assign is_s  = |spfx_hit;
  assign is_si = (op[7:5] == 3'b100) && SI_MAP[op[4:0]];
  assign rec   = split_fields(word, pick_format(op, is_s, is_si));
endmodule

// File: rtl/vlip_hold.sv
module vlip_hold
  import vlip_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  rec_t rec_in,
  input  logic out_ready,
  output logic out_valid,
  output logic sink_free,
  output rec_t rec_out
);
  assign sink_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      rec_out   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      rec_out   <= rec_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vlip_parser.sv
module vlip_parser
  import vlip_pkg::*;
#(
  parameter int                    NUM_SPFX  = 2,
  parameter logic [NUM_SPFX*8-1:0] SPFX_LIST = {8'hB3, 8'hB2},
  parameter logic [31:0]           SI_MAP    = 32'h00FF_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [2:0]  out_fmt,
  output logic [2:0]  out_nbytes,
  output logic [15:0] out_opcode,
  output logic [3:0]  out_ra,
  output logic [3:0]  out_rb,
  output logic [3:0]  out_base1,
  output logic [11:0] out_disp1,
  output logic [3:0]  out_base2,
  output logic [11:0] out_disp2,
  output logic [7:0]  out_imm,
  output logic        out_illegal
);
  // Named internal events for the checker
  logic              byte_take, insn_done, sink_free;
  logic [CNT_W-1:0]  fill_cnt;
  logic [WORD_W-1:0] word;
  rec_t              dec_rec, out_rec;

  vlip_collect u_collect (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .sink_free(sink_free), .in_ready(in_ready), .byte_take(byte_take),
    .insn_done(insn_done), .fill_cnt(fill_cnt), .word(word)
  );

  vlip_decode #(.NUM_SPFX(NUM_SPFX), .SPFX_LIST(SPFX_LIST), .SI_MAP(SI_MAP)) u_decode (
    .word(word), .rec(dec_rec)
  );

  vlip_hold u_hold (
    .clk(clk), .rst(rst), .load(insn_done), .rec_in(dec_rec),
    .out_ready(out_ready), .out_valid(out_valid), .sink_free(sink_free),
    .rec_out(out_rec)
  );

  assign out_fmt     = out_rec.fmt;
  assign out_nbytes  = out_rec.nbytes;
  assign out_opcode  = out_rec.opcode;
  assign out_ra      = out_rec.ra;
  assign out_rb      = out_rec.rb;
  assign out_base1   = out_rec.base1;
  assign out_disp1   = out_rec.disp1;
  assign out_base2   = out_rec.base2;
  assign out_disp2   = out_rec.disp2;
  assign out_imm     = out_rec.imm;
  assign out_illegal = out_rec.illegal;
endmodule

// File: rtl/vlip_checker.sv
module vlip_checker
  import vlip_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             insn_done,
  input logic [CNT_W-1:0] fill_cnt,
  input rec_t             out_rec
);
  p_len_fmt_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_rec.fmt == FMT_RR ? out_rec.nbytes == 3'd2 :
                   out_rec.fmt == FMT_SS ? out_rec.nbytes == 3'd6 :
                                           out_rec.nbytes == 3'd4));

  p_wide_op_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rec.opcode[15:8] != 8'h00) |-> out_rec.fmt == FMT_S);

  p_illegal_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rec.illegal) |-> (out_rec.fmt == FMT_RR && out_rec.opcode == 16'h0000));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |-> (out_valid && !out_ready));

  p_done_load_r9: assert property (@(posedge clk) disable iff (rst)
    insn_done |=> out_valid);

  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && fill_cnt == '0));

  p_realign_r11: assert property (@(posedge clk) disable iff (rst)
    insn_done |=> fill_cnt == '0);

  p_fill_range_r11: assert property (@(posedge clk) disable iff (rst)
    fill_cnt < CNT_W'(MAX_BYTES));
endmodule

bind vlip_parser vlip_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .insn_done(insn_done),
  .fill_cnt(fill_cnt), .out_rec(out_rec)
);

// File: tb/vlip_parser_test.sv
`timescale 1ns/1ps
module vlip_parser_test;
  typedef struct packed {
    logic [2:0] n; logic [2:0] fmt; logic [15:0] op;
    logic [3:0] ra; logic [3:0] rb; logic [3:0] b1; logic [11:0] d1;
    logic [3:0] b2; logic [11:0] d2; logic [7:0] imm; logic ill;
  } exp_t;
  typedef struct packed { logic [47:0] raw; exp_t e; } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{48'h1837_0000_0000, '{3'd2,3'd0,16'h0018,4'h3,4'h7,4'h0,12'h000,4'h0,12'h000,8'h00,1'b0}},
    '{48'h0045_0000_0000, '{3'd2,3'd0,16'h0000,4'h4,4'h5,4'h0,12'h000,4'h0,12'h000,8'h00,1'b1}},
    '{48'h5B35_C024_0000, '{3'd4,3'd1,16'h005B,4'h3,4'h5,4'h0,12'h000,4'hC,12'h024,8'h00,1'b0}},
    '{48'h9868_C024_0000, '{3'd4,3'd2,16'h0098,4'h6,4'h8,4'h0,12'h000,4'hC,12'h024,8'h00,1'b0}},
    '{48'h92F3_C231_0000, '{3'd4,3'd3,16'h0092,4'h0,4'h0,4'hC,12'h231,4'h0,12'h000,8'hF3,1'b0}},
    '{48'hD202_C106_C735, '{3'd6,3'd4,16'h00D2,4'h0,4'h0,4'hC,12'h106,4'hC,12'h735,8'h02,1'b0}},
    '{48'hB220_D04C_0000, '{3'd4,3'd5,16'hB220,4'h0,4'h0,4'h0,12'h000,4'hD,12'h04C,8'h00,1'b0}},
    '{48'h8012_3456_0000, '{3'd4,3'd2,16'h0080,4'h1,4'h2,4'h0,12'h000,4'h3,12'h456,8'h00,1'b0}},
    '{48'h41FF_EFFF_0000, '{3'd4,3'd1,16'h0041,4'hF,4'hF,4'h0,12'h000,4'hE,12'hFFF,8'h00,1'b0}},
    '{48'hFFAB_1234_5678, '{3'd6,3'd4,16'h00FF,4'h0,4'h0,4'h1,12'h234,4'h5,12'h678,8'hAB,1'b0}},
    '{48'hB301_0000_0000, '{3'd4,3'd5,16'hB301,4'h0,4'h0,4'h0,12'h000,4'h0,12'h000,8'h00,1'b0}},
    '{48'h977E_1001_0000, '{3'd4,3'd3,16'h0097,4'h0,4'h0,4'h1,12'h001,4'h0,12'h000,8'h7E,1'b0}}
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid, out_illegal;
  logic [2:0] out_fmt, out_nbytes;
  logic [15:0] out_opcode;
  logic [3:0] out_ra, out_rb, out_base1, out_base2;
  logic [11:0] out_disp1, out_disp2;
  logic [7:0] out_imm;
  int checks = 0, fails = 0;
  bit finished = 0;
  exp_t got [$];
  exp_t snap;

  always #4 clk = ~clk;

  vlip_parser uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_fmt(out_fmt), .out_nbytes(out_nbytes),
    .out_opcode(out_opcode), .out_ra(out_ra), .out_rb(out_rb), .out_base1(out_base1),
    .out_disp1(out_disp1), .out_base2(out_base2), .out_disp2(out_disp2),
    .out_imm(out_imm), .out_illegal(out_illegal)
  );

  function automatic exp_t cur();
    return '{out_nbytes, out_fmt, out_opcode, out_ra, out_rb, out_base1, out_disp1,
             out_base2, out_disp2, out_imm, out_illegal};
  endfunction

  always @(negedge clk)
    if (!rst && out_valid && out_ready) got.push_back(cur());

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at posedge+2; leaves the caller at posedge+2 after acceptance.
  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    forever begin @(negedge clk); if (in_ready) break; end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic string fmt_tag(input exp_t e);
    if (e.ill) return "R7";
    case (e.fmt)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    idle(3);
    // R10: reset state
    chk("R10 reset out_valid", out_valid, 0);
    chk("R10 reset in_ready", in_ready, 1);
    rst = 1'b0;
    idle(1);

    // Table walk, back to back (R11)
    for (int v = 0; v < NV; v++)
      for (int k = 0; k < int'(TBL[v].e.n); k++)
        push(TBL[v].raw[47-8*k -: 8]);
    idle(3);
    chk("R11 record count", got.size(), NV);
    for (int v = 0; v < NV && v < got.size(); v++) begin
      chk("R1 length", got[v].n, TBL[v].e.n);
      chk(fmt_tag(TBL[v].e), got[v], TBL[v].e);
    end

    // Backpressure: R8, R9
    got.delete();
    out_ready = 1'b0;
    push(8'h18); push(8'h37);
    push(8'h5B); push(8'h35); push(8'hC0);
    in_valid = 1'b1; in_byte = 8'h24;
    @(negedge clk);
    snap = cur();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 stall on final byte", in_ready, 0);
      chk("R8 record held", {out_valid, cur()}, {1'b1, snap});
    end
    @(posedge clk); #2;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 ready when drained", in_ready, 1);
    @(posedge clk); #2;
    in_valid = 1'b0;
    idle(3);
    chk("R8 no loss count", got.size(), 2);
    if (got.size() == 2) begin
      chk("R8 first after hold", got[0], TBL[0].e);
      chk("R9 second after hold", got[1], TBL[2].e);
    end

    // Reset mid-instruction: R10
    got.delete();
    out_ready = 1'b0;
    push(8'h18); push(8'h37);
    push(8'h5B); push(8'h35);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 out_valid cleared", out_valid, 0);
    chk("R10 in_ready after reset", in_ready, 1);
    @(posedge clk); #2;
    out_ready = 1'b1;
    push(8'h41); push(8'hFF); push(8'hEF); push(8'hFF);
    idle(3);
    chk("R10 realigned count", got.size(), 1);
    if (got.size() == 1) chk("R10 realigned record", got[0], TBL[8].e);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule